// File: doc/BRIEF.md
# UART Transmit DMA Request Generator

This block is the transmit store of a serial port, together with the logic that asks a DMA engine for more data. Characters arrive from the DMA engine through a write strobe. They are held either in a 16-entry FIFO or, when the FIFO is switched off, in a single holding slot. The serial shifter takes characters out through a pop strobe. It sees the oldest character and a valid flag.

The request output follows one of two rules. In single-character mode it is raised only when the store is completely empty, and it falls as soon as one character is stored. In multi-character mode, which applies only with the FIFO on, it stays raised while any FIFO entry is free and falls only when the FIFO is full. The request is gated by a transmit-channel enable bit. Software loads that bit and a companion receive-channel enable bit. When automatic clearing is allowed, a terminal-count pulse from the DMA controller drops both bits. That ends the transfer without software action.

Top module: `uart_tx_dma_req`

## Requirements
- R1: While rst_ni is low (asynchronous, active low), dma_req_o, tx_en_o, rx_en_o, tx_valid_o and ovf_o are all 0 and the store is empty.
- R2: With tx_en_o at 0, dma_req_o stays 0 whatever the occupancy, mode or FIFO setting.
- R3: With dma_mode_i = 0, dma_req_o is 1 exactly when the store holds no character (FIFO on or off) and tx_en_o is 1. It drops after the first character is stored, even if FIFO entries remain free.
- R4: With dma_mode_i = 1 and fifo_en_i = 1, dma_req_o is 1 while fewer than 16 characters are stored, and 0 once 16 are stored.
- R5: With dma_mode_i = 1 and fifo_en_i = 0, the request follows the R3 rule.
- R6: Capacity is 16 characters with fifo_en_i = 1 and 1 character with fifo_en_i = 0. rd_data_o presents the oldest stored character, in write order, and tx_valid_o is 1 while any character is stored.
- R7: A write while the store is full is dropped. The following cycle, ovf_o is 1 for exactly one cycle.
- R8: When tc_i and auto_clr_i are both 1 at a clock edge, tx_en_o and rx_en_o are 0 after that edge, and dma_req_o is 0. This holds even if en_wr_i is 1 in the same cycle.
- R9: When tc_i is 1 and auto_clr_i is 0, tx_en_o and rx_en_o keep their values.
- R10: dma_req_o is a register. It takes its new value at the same clock edge that stores or removes the character changing the occupancy.
- R11: A write and a pop in the same cycle on a non-full store both take effect, and the occupancy stays the same. On a full store the pop takes effect and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_wr_i | input | 1 | Load strobe for the two enable bits |
| tx_en_d_i | input | 1 | Value loaded into the transmit-channel enable |
| rx_en_d_i | input | 1 | Value loaded into the receive-channel enable |
| auto_clr_i | input | 1 | Allow terminal count to clear both enables |
| tc_i | input | 1 | Terminal-count pulse from the DMA controller |
| fifo_en_i | input | 1 | 1 = 16-entry FIFO, 0 = single holding slot |
| dma_mode_i | input | 1 | 0 = single-character request, 1 = multi-character request |
| wr_i | input | 1 | Character write strobe from the DMA engine |
| wr_data_i | input | 8 | Character to store |
| pop_i | input | 1 | Pop strobe from the shifter |
| dma_req_o | output | 1 | Registered DMA request |
| tx_en_o | output | 1 | Transmit-channel enable |
| rx_en_o | output | 1 | Receive-channel enable |
| rd_data_o | output | 8 | Oldest stored character |
| tx_valid_o | output | 1 | Store holds at least one character |
| ovf_o | output | 1 | One-cycle pulse after a dropped write |

## Verification
Two pairs of functions can meet in one cycle here. The first is a character write from the DMA engine and a pop from the shifter. The bench provokes it on a store holding one character, where it expects the new character at the head and the request still low. It also provokes it on a full FIFO in multi-character mode, where it expects an overflow pulse and the request raised again because one entry is now free. The second pair is a terminal count with automatic clearing and a software load of the enables. The bench issues both in the same cycle and expects both enables to read 0 afterwards.

// File: rtl/uart_txdma_pkg.sv
`timescale 1ns/1ps
package uart_txdma_pkg;
  typedef enum logic {
    REQ_SINGLE = 1'b0,
    REQ_MULTI  = 1'b1
  } req_mode_e;
endpackage

// File: rtl/txd_store.sv
`timescale 1ns/1ps
module txd_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pop_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cnt_nxt_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              valid_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q, cap;
  logic              full, wr_ok, pop_ok, ovf_q;

  // holding slot mode limits capacity to one entry of the same array
  assign cap    = fifo_en_i ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full   = (cnt_q >= cap);
  assign wr_ok  = wr_i && !full;
  assign pop_ok = pop_i && (cnt_q != '0);

  assign cnt_nxt_o = cnt_q + CNT_W'(wr_ok) - CNT_W'(pop_ok);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt_o;
      ovf_q <= wr_i && full;
      if (wr_ok)  wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok) rd_ptr_q <= ptr_inc(rd_ptr_q);
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_ptr_q] <= wr_data_i;
  end

  assign cnt_o     = cnt_q;
  assign rd_data_o = mem_q[rd_ptr_q];
  assign valid_o   = (cnt_q != '0);
  assign ovf_o     = ovf_q;

  // R6
  cap_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  // R7
  drop_on_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full && !pop_i) |=> (cnt_q == $past(cnt_q)) && ovf_q);

  // R7
  ovf_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !$past(wr_i, 2)) |-> !$past(ovf_q));
endmodule

// File: rtl/txd_enable.sv
`timescale 1ns/1ps
module txd_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_wr_i,
  input  logic tx_en_d_i,
  input  logic rx_en_d_i,
  input  logic tc_i,
  input  logic auto_clr_i,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic tx_en_nxt_o
);
  logic tx_en_q, rx_en_q, rx_en_nxt, clr;

  assign clr = tc_i && auto_clr_i;

  // terminal-count clear wins over a same-cycle load
  always_comb begin
    tx_en_nxt_o = tx_en_q;
    rx_en_nxt   = rx_en_q;
    if (en_wr_i) begin
      tx_en_nxt_o = tx_en_d_i;
      rx_en_nxt   = rx_en_d_i;
    end
    if (clr) begin
      tx_en_nxt_o = 1'b0;
      rx_en_nxt   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
    end else begin
      tx_en_q <= tx_en_nxt_o;
      rx_en_q <= rx_en_nxt;
    end
  end

  assign tx_en_o = tx_en_q;
  assign rx_en_o = rx_en_q;

  // R8
  tc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i && auto_clr_i) |=> !tx_en_q && !rx_en_q);

  // R9
  tc_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i && !auto_clr_i && !en_wr_i) |=> $stable(tx_en_q) && $stable(rx_en_q));
endmodule

// File: rtl/txd_req.sv
`timescale 1ns/1ps
module txd_req
  import uart_txdma_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             tx_en_nxt_i,
  input  logic             fifo_en_i,
  input  req_mode_e        mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic             req_o
);
  logic multi, req_d, req_q;

  // multi-character rule needs the FIFO; otherwise fall back to single
  assign multi = (mode_i == REQ_MULTI) && fifo_en_i;

  always_comb begin
    if (!tx_en_nxt_i)  req_d = 1'b0;
    else if (multi)    req_d = (cnt_nxt_i != CNT_W'(DEPTH));
    else               req_d = (cnt_nxt_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;

  // R2
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> !req_q);

  // R3 R5
  single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !$past(multi)) |-> (cnt_i == '0));

  // R4
  multi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> (cnt_i != CNT_W'(DEPTH)));
endmodule

// File: rtl/uart_tx_dma_req.sv
`timescale 1ns/1ps
module uart_tx_dma_req
  import uart_txdma_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_wr_i,
  input  logic              tx_en_d_i,
  input  logic              rx_en_d_i,
  input  logic              auto_clr_i,
  input  logic              tc_i,
  input  logic              fifo_en_i,
  input  logic              dma_mode_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pop_i,
  output logic              dma_req_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              tx_valid_o,
  output logic              ovf_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             tx_en_nxt;
  req_mode_e        mode;

  assign mode = req_mode_e'(dma_mode_i);

  txd_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni, .fifo_en_i, .wr_i, .wr_data_i, .pop_i,
    .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .rd_data_o, .valid_o(tx_valid_o), .ovf_o
  );

  txd_enable u_enable (
    .clk_i, .rst_ni, .en_wr_i, .tx_en_d_i, .rx_en_d_i, .tc_i, .auto_clr_i,
    .tx_en_o, .rx_en_o, .tx_en_nxt_o(tx_en_nxt)
  );

  txd_req #(.DEPTH(DEPTH)) u_req (
    .clk_i, .rst_ni, .tx_en_i(tx_en_o), .tx_en_nxt_i(tx_en_nxt), .fifo_en_i,
    .mode_i(mode), .cnt_i(cnt), .cnt_nxt_i(cnt_nxt), .req_o(dma_req_o)
  );

  // R10
  req_on_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && !tc_i && !en_wr_i && !dma_mode_i && pop_i && !wr_i && cnt == CNT_W'(1))
      |=> dma_req_o);
endmodule

// File: tb/uart_tx_dma_req_bench.sv
`timescale 1ns/1ps
module uart_tx_dma_req_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_wr = 0, tx_en_d = 0, rx_en_d = 0, auto_clr = 0, tc = 0;
  logic       fifo_en = 0, dma_mode = 0, wr = 0, pop = 0;
  logic [7:0] wr_data = '0;
  logic       dma_req, tx_en, rx_en, tx_valid, ovf;
  logic [7:0] rd_data;
  int         n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  uart_tx_dma_req u_uart_tx_dma_req (
    .clk_i(clk), .rst_ni(rst_n), .en_wr_i(en_wr), .tx_en_d_i(tx_en_d),
    .rx_en_d_i(rx_en_d), .auto_clr_i(auto_clr), .tc_i(tc), .fifo_en_i(fifo_en),
    .dma_mode_i(dma_mode), .wr_i(wr), .wr_data_i(wr_data), .pop_i(pop),
    .dma_req_o(dma_req), .tx_en_o(tx_en), .rx_en_o(rx_en), .rd_data_o(rd_data),
    .tx_valid_o(tx_valid), .ovf_o(ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_en(input logic t, input logic r);
    en_wr = 1; tx_en_d = t; rx_en_d = r; step(); en_wr = 0;
  endtask

  task automatic put(input logic [7:0] d);
    wr = 1; wr_data = d; step(); wr = 0;
  endtask

  task automatic take();
    pop = 1; step(); pop = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 20; i++) if (tx_valid) take();
  endtask

  task automatic t_reset();
    chk("R1 req", dma_req, 0); chk("R1 tx_en", tx_en, 0);
    chk("R1 rx_en", rx_en, 0); chk("R1 valid", tx_valid, 0); chk("R1 ovf", ovf, 0);
  endtask

  task automatic t_disabled();
    fifo_en = 1; dma_mode = 0; step(); step();
    chk("R2 off mode0", dma_req, 0);
    dma_mode = 1; step();
    chk("R2 off mode1", dma_req, 0);
    dma_mode = 0;
  endtask

  task automatic t_single_fifo();
    fifo_en = 1; dma_mode = 0; set_en(1, 1);
    chk("R3 empty req", dma_req, 1);
    put(8'h3c);
    chk("R10 req drop at write edge", dma_req, 0);
    chk("R6 head", rd_data, 8'h3c);
    put(8'h3d);
    chk("R3 free space no req", dma_req, 0);
    take();
    chk("R3 one left", dma_req, 0);
    take();
    chk("R10 req at pop edge", dma_req, 1);
    chk("R6 empty", tx_valid, 0);
  endtask

  task automatic t_single_hold();
    fifo_en = 0; dma_mode = 0; step();
    chk("R3 hold empty", dma_req, 1);
    put(8'ha1);
    chk("R3 hold filled", dma_req, 0);
    put(8'hb2);
    chk("R7 ovf pulse", ovf, 1);
    chk("R6 hold cap 1", rd_data, 8'ha1);
    step();
    chk("R7 ovf one cycle", ovf, 0);
    take();
    chk("R6 hold empty after pop", tx_valid, 0);
    chk("R3 hold req back", dma_req, 1);
  endtask

  task automatic t_multi();
    fifo_en = 1; dma_mode = 1; step();
    chk("R4 empty req", dma_req, 1);
    for (int i = 0; i < 15; i++) put(8'(i + 16));
    chk("R4 15 stored", dma_req, 1);
    put(8'd31);
    chk("R4 full no req", dma_req, 0);
    put(8'hee);
    chk("R7 ovf fifo", ovf, 1);
    take();
    chk("R4 free entry req", dma_req, 1);
    for (int i = 1; i < 16; i++) begin
      chk("R6 order", rd_data, i + 16);
      take();
    end
    chk("R6 drained", tx_valid, 0);
  endtask

  task automatic t_multi_nofifo();
    fifo_en = 0; dma_mode = 1; step();
    chk("R5 empty req", dma_req, 1);
    put(8'h55);
    chk("R5 single slot drop", dma_req, 0);
    drain(); dma_mode = 0; fifo_en = 1; step();
  endtask

  task automatic t_same_cycle();
    fifo_en = 1; dma_mode = 0; step();
    put(8'h10);
    wr = 1; wr_data = 8'h20; pop = 1; step(); wr = 0; pop = 0;
    chk("R11 head after wr+pop", rd_data, 8'h20);
    chk("R11 valid", tx_valid, 1);
    chk("R11 req stays low", dma_req, 0);
    drain();
    dma_mode = 1;
    for (int i = 0; i < 16; i++) put(8'(i));
    chk("R11 full", dma_req, 0);
    wr = 1; wr_data = 8'hff; pop = 1; step(); wr = 0; pop = 0;
    chk("R11 write dropped ovf", ovf, 1);
    chk("R11 pop taken req", dma_req, 1);
    chk("R11 head", rd_data, 1);
    drain(); dma_mode = 0; step();
  endtask

  task automatic t_tc();
    set_en(1, 1); auto_clr = 0;
    tc = 1; step(); tc = 0;
    chk("R9 tx kept", tx_en, 1); chk("R9 rx kept", rx_en, 1);
    chk("R9 req kept", dma_req, 1);
    auto_clr = 1; tc = 1; step(); tc = 0;
    chk("R8 tx cleared", tx_en, 0); chk("R8 rx cleared", rx_en, 0);
    chk("R8 req low", dma_req, 0);
    set_en(1, 1);
    tc = 1; en_wr = 1; tx_en_d = 1; rx_en_d = 1; step(); tc = 0; en_wr = 0;
    chk("R8 tc beats load tx", tx_en, 0); chk("R8 tc beats load rx", rx_en, 0);
  endtask

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1; step();
    t_disabled();
    t_single_fifo();
    t_single_hold();
    t_multi();
    t_multi_nofifo();
    t_same_cycle();
    t_tc();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule